// File: doc/BRIEF.md
# Serial Command Slave for a Digital Potentiometer

This block sits on a two-wire serial bus and turns the transactions it sees there into register commands for one digitally controlled potentiometer. It filters the clock and data lines against a fast system clock and detects start and stop conditions. It checks an identification byte against a fixed device type and three address pins. It then decodes an instruction byte that holds an opcode and a register pointer. After that it either takes in one data byte, sends one data byte back, queues a transfer, or enters a streaming mode in which every clock pulse moves the wiper by one tap.

The register controller behind it receives a one-cycle command strobe with a command kind, a register pointer and write data. It also receives one-cycle step pulses, and it returns read data and a busy flag. The slave drives the data line only by pulling it low, through an output enable.

Top module: `pot_cmd_slave`

## Requirements
- R1: A start (data falls while clock is high) begins a new transaction from any state and discards a partly received one. A stop (data rises while clock is high) returns the slave to idle. Incoming bits are sampled on the clock rising edge, most significant bit first.
- R2: The first byte is acknowledged only when its upper four bits are 0101, bit 3 is 0 and bits 2..0 equal `addr_pins`. Any other first byte gets no acknowledge, and the slave ignores the bus until the next start.
- R3: While `busy_i` is high the first byte gets no acknowledge, even when it matches. This allows completion polling.
- R4: Instruction byte: bits 7..4 are the opcode, bits 3..2 select the register and bits 1..0 the bank. `reg_ptr` = {bank, register}. Legal opcodes are 1001 read wiper, 1010 write wiper, 1011 read data register, 1100 write data register, 1101 data register to wiper, 1110 wiper to data register and 0010 step mode. The two data register access opcodes accept any bank. All other legal opcodes need bank 00. Any other byte is not acknowledged.
- R5: For write wiper and write data register, the third byte is acknowledged. A stop then yields one `cmd_stb` cycle with `cmd_kind` 0 (wiper write) or 1 (data register write), and with `reg_ptr` and `wr_data` holding that byte.
- R6: For the two transfer opcodes, a stop right after the acknowledged instruction yields one `cmd_stb` with `cmd_kind` 2 (register to wiper) or 3 (wiper to register) and the decoded `reg_ptr`.
- R7: For the read opcodes the slave shifts `rd_data_i` out MSB first. Each bit changes after a clock falling edge. `rd_wiper` is 1 for the wiper read and 0 for a data register read.
- R8: In step mode, each clock pulse produces one `step_up` pulse if data was high at the rising edge, or one `step_dn` pulse if it was low. The pulse comes after the falling edge. The rising clock of the closing stop produces no step.
- R9: A command with too few bytes before the stop, or with extra clocked bits after its final byte, issues no strobe.
- R10: After reset `sda_oe`, `cmd_stb`, `step_up` and `step_dn` are all 0.
- R11: `sda_oe` changes only while the filtered clock is low. At most one of `cmd_stb`, `step_up` and `step_dn` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_pins | input | 3 | Board-strapped slave address |
| busy_i | input | 1 | Nonvolatile store in progress |
| rd_data_i | input | 8 | Read data for the selected register |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_kind | output | 2 | 0 wiper write, 1 register write, 2 register to wiper, 3 wiper to register |
| reg_ptr | output | 4 | {bank, register} |
| wr_data | output | 8 | Data byte for write commands |
| rd_wiper | output | 1 | Read source: 1 wiper, 0 data register |
| step_up | output | 1 | One-tap step toward the high end |
| step_dn | output | 1 | One-tap step toward the low end |

## Verification
The bench builds the block with its default two synchroniser stages and a four-cycle glitch filter. With these values the filtered lines trail the bus by about seven system clocks, well inside a 100 ns quarter bit. Acknowledge timing, read bit placement and the separation of step pulses from the closing stop can therefore all be observed at the bus pins. Address pins strapped to 101 make a one-bit address mismatch and a wrong device type reachable as separate cases.

// File: rtl/pot_cmd_pkg.sv
`timescale 1ns/1ps
package pot_cmd_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b0101;

  typedef enum logic [3:0] {
    OP_RD_WIPER = 4'b1001,
    OP_WR_WIPER = 4'b1010,
    OP_RD_DREG  = 4'b1011,
    OP_WR_DREG  = 4'b1100,
    OP_D2W      = 4'b1101,
    OP_W2D      = 4'b1110,
    OP_STEP     = 4'b0010
  } opcode_e;

  typedef enum logic [1:0] {
    K_WR_WIPER = 2'd0,
    K_WR_DREG  = 2'd1,
    K_D2W      = 2'd2,
    K_W2D      = 2'd3
  } cmd_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID,
    ST_INSTR,
    ST_WDATA,
    ST_RDATA,
    ST_HOLD,
    ST_STEP,
    ST_IGNORE
  } slv_state_e;

  function automatic logic op_legal(input logic [3:0] op, input logic [1:0] bank);
    case (op)
      OP_RD_DREG, OP_WR_DREG:                      op_legal = 1'b1;
      OP_RD_WIPER, OP_WR_WIPER, OP_D2W, OP_W2D,
      OP_STEP:                                     op_legal = (bank == 2'b00);
      default:                                     op_legal = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pot_line_filter.sv
`timescale 1ns/1ps
module pot_line_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   FILT_LEN    = 4,
  parameter logic IDLE_VAL    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   out_q, out_d;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= IDLE_VAL;
        else        sync_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{IDLE_VAL}};
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      end
    end
  endgenerate

  always_comb begin
    out_d = out_q;
    cnt_d = '0;
    if (synced != out_q) begin
      if (cnt_q == CW'(FILT_LEN - 1)) out_d = synced;
      else                            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= IDLE_VAL;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/pot_bus_events.sv
`timescale 1ns/1ps
module pot_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  =  scl_f & ~scl_q;
  assign scl_fall  = ~scl_f &  scl_q;
  assign start_evt =  scl_f &  scl_q &  sda_q & ~sda_f;
  assign stop_evt  =  scl_f &  scl_q & ~sda_q &  sda_f;
endmodule

// File: rtl/pot_cmd_fsm.sv
`timescale 1ns/1ps
module pot_cmd_fsm
  import pot_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [2:0] addr_pins,
  input  logic       busy_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe,
  output logic       cmd_stb,
  output logic [1:0] cmd_kind,
  output logic [3:0] reg_ptr,
  output logic [7:0] wr_data,
  output logic       rd_wiper,
  output logic       step_up,
  output logic       step_dn
);
  slv_state_e state_q, state_d, nxt_q, nxt_d;
  logic [3:0] cnt_q, cnt_d;
  logic       ack_q, ack_d;
  logic [7:0] sh_q, sh_d;
  logic [3:0] ptr_q, ptr_d;
  logic [7:0] data_q, data_d;
  logic [1:0] kind_q, kind_d;
  logic       rdw_q, rdw_d;
  logic       drv_q, drv_d;
  logic       dir_q, dir_d;
  logic       seen_q, seen_d;
  logic       stb_q, stb_d;
  logic       up_q, up_d, dn_q, dn_d;
  logic [3:0] op_in;
  logic [1:0] bank_in;

  assign op_in   = sh_q[7:4];
  assign bank_in = sh_q[1:0];

  always_comb begin
    state_d = state_q;
    nxt_d   = nxt_q;
    cnt_d   = cnt_q;
    ack_d   = ack_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    data_d  = data_q;
    kind_d  = kind_q;
    rdw_d   = rdw_q;
    drv_d   = drv_q;
    dir_d   = dir_q;
    seen_d  = seen_q;
    stb_d   = 1'b0;
    up_d    = 1'b0;
    dn_d    = 1'b0;

    if (start_evt) begin
      state_d = ST_ID;
      cnt_d   = '0;
      ack_d   = 1'b0;
      drv_d   = 1'b0;
      seen_d  = 1'b0;
    end else if (stop_evt) begin
      stb_d   = (state_q == ST_HOLD);
      state_d = ST_IDLE;
      ack_d   = 1'b0;
      drv_d   = 1'b0;
    end else begin
      case (state_q)
        ST_ID, ST_INSTR, ST_WDATA: begin
          if (scl_rise && !ack_q && cnt_q < 4'd8) begin
            sh_d  = {sh_q[6:0], sda_f};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && ack_q) begin
            drv_d   = 1'b0;
            ack_d   = 1'b0;
            cnt_d   = '0;
            seen_d  = 1'b0;
            state_d = nxt_q;
            if (nxt_q == ST_RDATA) begin
              sh_d  = rd_data_i;
              drv_d = ~rd_data_i[7];
            end
          end else if (scl_fall && cnt_q == 4'd8) begin
            state_d = ST_IGNORE;
            if (state_q == ST_ID) begin
              if (sh_q[7:4] == DEV_TYPE && !sh_q[3] && sh_q[2:0] == addr_pins && !busy_i) begin
                state_d = state_q;
                drv_d   = 1'b1;
                ack_d   = 1'b1;
                nxt_d   = ST_INSTR;
              end
            end else if (state_q == ST_INSTR) begin
              if (op_legal(op_in, bank_in)) begin
                state_d = state_q;
                drv_d   = 1'b1;
                ack_d   = 1'b1;
                ptr_d   = {sh_q[1:0], sh_q[3:2]};
                rdw_d   = (op_in == OP_RD_WIPER);
                case (op_in)
                  OP_RD_WIPER, OP_RD_DREG: nxt_d = ST_RDATA;
                  OP_WR_WIPER: begin nxt_d = ST_WDATA; kind_d = K_WR_WIPER; end
                  OP_WR_DREG:  begin nxt_d = ST_WDATA; kind_d = K_WR_DREG;  end
                  OP_D2W:      begin nxt_d = ST_HOLD;  kind_d = K_D2W;      end
                  OP_W2D:      begin nxt_d = ST_HOLD;  kind_d = K_W2D;      end
                  default:     nxt_d = ST_STEP;
                endcase
              end
            end else begin
              state_d = state_q;
              drv_d   = 1'b1;
              ack_d   = 1'b1;
              data_d  = sh_q;
              nxt_d   = ST_HOLD;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              drv_d   = 1'b0;
              state_d = ST_IGNORE;
            end else begin
              sh_d  = {sh_q[6:0], 1'b0};
              drv_d = ~sh_q[6];
            end
          end
        end
        ST_HOLD: begin
          if (scl_rise)                seen_d  = 1'b1;
          else if (scl_fall && seen_q) state_d = ST_IGNORE;
        end
        ST_STEP: begin
          if (scl_rise) begin
            dir_d  = sda_f;
            seen_d = 1'b1;
          end else if (scl_fall && seen_q) begin
            up_d   = dir_q;
            dn_d   = ~dir_q;
            seen_d = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      nxt_q   <= ST_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      sh_q    <= '0;
      ptr_q   <= '0;
      data_q  <= '0;
      kind_q  <= '0;
      rdw_q   <= 1'b0;
      drv_q   <= 1'b0;
      dir_q   <= 1'b0;
      seen_q  <= 1'b0;
      stb_q   <= 1'b0;
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      nxt_q   <= nxt_d;
      cnt_q   <= cnt_d;
      ack_q   <= ack_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      data_q  <= data_d;
      kind_q  <= kind_d;
      rdw_q   <= rdw_d;
      drv_q   <= drv_d;
      dir_q   <= dir_d;
      seen_q  <= seen_d;
      stb_q   <= stb_d;
      up_q    <= up_d;
      dn_q    <= dn_d;
    end
  end

  assign sda_oe   = drv_q;
  assign cmd_stb  = stb_q;
  assign cmd_kind = kind_q;
  assign reg_ptr  = ptr_q;
  assign wr_data  = data_q;
  assign rd_wiper = rdw_q;
  assign step_up  = up_q;
  assign step_dn  = dn_q;

  logic unused_scl;
  assign unused_scl = scl_f;
endmodule

// File: rtl/pot_cmd_slave.sv
`timescale 1ns/1ps
module pot_cmd_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] addr_pins,
  input  logic       busy_i,
  input  logic [7:0] rd_data_i,
  output logic       cmd_stb,
  output logic [1:0] cmd_kind,
  output logic [3:0] reg_ptr,
  output logic [7:0] wr_data,
  output logic       rd_wiper,
  output logic       step_up,
  output logic       step_dn
);
  localparam int NLINES = 2;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [NLINES-1:0] raw_lines, filt_lines;
  logic              scl_filt, sda_filt;
  logic              scl_rise, scl_fall, start_evt, stop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign raw_lines = {sda_i, scl_i};

  generate
    for (genvar g = 0; g < NLINES; g++) begin : g_line
      pot_line_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN),
        .IDLE_VAL   (1'b1)
      ) u_filt (
        .clk  (clk),
        .rst_n(rst_sync_n),
        .din  (raw_lines[g]),
        .dout (filt_lines[g])
      );
    end
  endgenerate

  assign scl_filt = filt_lines[0];
  assign sda_filt = filt_lines[1];

  pot_bus_events u_evt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_f    (scl_filt),
    .sda_f    (sda_filt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  pot_cmd_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_f    (scl_filt),
    .sda_f    (sda_filt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .addr_pins(addr_pins),
    .busy_i   (busy_i),
    .rd_data_i(rd_data_i),
    .sda_oe   (sda_oe),
    .cmd_stb  (cmd_stb),
    .cmd_kind (cmd_kind),
    .reg_ptr  (reg_ptr),
    .wr_data  (wr_data),
    .rd_wiper (rd_wiper),
    .step_up  (step_up),
    .step_dn  (step_dn)
  );
endmodule

// File: rtl/pot_cmd_slave_chk.sv
`timescale 1ns/1ps
module pot_cmd_slave_chk (
  input logic clk,
  input logic rst_sync_n,
  input logic scl_filt,
  input logic scl_fall,
  input logic stop_evt,
  input logic sda_oe,
  input logic cmd_stb,
  input logic step_up,
  input logic step_dn
);
  // R11: never two strobes in one cycle
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({cmd_stb, step_up, step_dn}));

  // R11: the pull-down changes only while the clock line is low
  a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(sda_oe) |-> !scl_filt);

  // R5 / R6: a command strobe follows a stop condition
  a_r5_issue_on_stop: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_stb |-> $past(stop_evt));

  // R5: the strobe lasts a single cycle
  a_r5_stb_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_stb |=> !cmd_stb);

  // R8: steps are issued only after a clock falling edge
  a_r8_step_on_fall: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_up || step_dn) |-> $past(scl_fall));
endmodule

bind pot_cmd_slave pot_cmd_slave_chk u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .scl_filt  (scl_filt),
  .scl_fall  (scl_fall),
  .stop_evt  (stop_evt),
  .sda_oe    (sda_oe),
  .cmd_stb   (cmd_stb),
  .step_up   (step_up),
  .step_dn   (step_dn)
);

// File: tb/test_pot_cmd_slave.sv
`timescale 1ns/1ps
module test_pot_cmd_slave;
  localparam int Q = 100;
  localparam int H = 200;

  logic clk, rst_n;
  logic scl_m, sda_m, busy;
  logic [2:0] pins;
  logic sda_oe, cmd_stb, rd_wiper, step_up, step_dn;
  logic [1:0] cmd_kind;
  logic [3:0] reg_ptr;
  logic [7:0] wr_data, rd_data;
  wire  sda_line = sda_m & ~sda_oe;

  int tests, fails;
  logic [14:0] exp_q[$];

  assign rd_data = rd_wiper ? 8'h3C : {reg_ptr, ~reg_ptr};

  pot_cmd_slave i_pot_cmd_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_pins(pins), .busy_i(busy), .rd_data_i(rd_data), .cmd_stb(cmd_stb),
    .cmd_kind(cmd_kind), .reg_ptr(reg_ptr), .wr_data(wr_data), .rd_wiper(rd_wiper),
    .step_up(step_up), .step_dn(step_dn));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [14:0] item(input logic [2:0] t, input logic [3:0] p, input logic [7:0] d);
    return {t, p, d};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (cmd_stb || step_up || step_dn)) begin
      logic [14:0] got, exp;
      if (cmd_stb)      got = item({1'b0, cmd_kind}, reg_ptr, (cmd_kind <= 2'd1) ? wr_data : 8'h00);
      else if (step_up) got = item(3'd4, 4'h0, 8'h00);
      else              got = item(3'd5, 4'h0, 8'h00);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected strobe", {1'b0, got}, 16'h0);
      end else begin
        exp = exp_q.pop_front();
        chk(got == exp, "R5/R6/R8 strobe", {1'b0, got}, {1'b0, exp});
      end
    end
  end

  task automatic start_c; sda_m = 1; #Q; scl_m = 1; #Q; sda_m = 0; #Q; scl_m = 0; #Q; endtask
  task automatic stop_c;  sda_m = 0; #Q; scl_m = 1; #Q; sda_m = 1; #Q; #(4*Q); endtask
  task automatic send_bit(input logic b); sda_m = b; #Q; scl_m = 1; #H; scl_m = 0; #Q; endtask
  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1; #Q; scl_m = 1; #(H/2); ack = !sda_line; #(H/2); scl_m = 0; #Q;
  endtask
  task automatic recv_byte(output logic [7:0] d);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1; #Q; scl_m = 1; #(H/2); d = {d[6:0], sda_line}; #(H/2); scl_m = 0; #Q;
    end
    send_bit(1'b1);
  endtask

  bit done;
  initial begin
    #(150000 * 10);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] d;
    tests = 0; fails = 0; done = 0;
    scl_m = 1; sda_m = 1; busy = 0; pins = 3'b101; rst_n = 0;
    #100;
    chk(sda_oe == 0 && cmd_stb == 0 && step_up == 0 && step_dn == 0, "R10 reset",
        {12'h0, sda_oe, cmd_stb, step_up, step_dn}, 16'h0);
    rst_n = 1; #200;

    // R5 wiper write
    start_c; send_byte(8'h55, a); chk(a, "R2 id ack", {15'h0, a}, 16'h1);
    send_byte(8'hA0, a); chk(a, "R4 instr ack", {15'h0, a}, 16'h1);
    send_byte(8'h5A, a); chk(a, "R5 data ack", {15'h0, a}, 16'h1);
    exp_q.push_back(item(3'd0, 4'h0, 8'h5A)); stop_c;

    // R5 data register write, bank 2 reg 1
    start_c; send_byte(8'h55, a); send_byte(8'hC6, a);
    chk(a, "R4 instr ack any bank", {15'h0, a}, 16'h1);
    send_byte(8'hC3, a); exp_q.push_back(item(3'd1, 4'h9, 8'hC3)); stop_c;

    // R7 data register read, bank 3 reg 2
    start_c; send_byte(8'h55, a); send_byte(8'hBB, a); recv_byte(d); stop_c;
    chk(d == 8'hE1, "R7 dreg read", {8'h0, d}, 16'h00E1);
    // R7 wiper read
    start_c; send_byte(8'h55, a); send_byte(8'h90, a); recv_byte(d); stop_c;
    chk(d == 8'h3C, "R7 wiper read", {8'h0, d}, 16'h003C);

    // R2 wrong address, wrong type, bit3 set
    start_c; send_byte(8'h54, a); chk(!a, "R2 addr mismatch", {15'h0, a}, 16'h0);
    send_byte(8'hA0, a); chk(!a, "R2 ignored after nack", {15'h0, a}, 16'h0);
    send_byte(8'h11, a); stop_c;
    start_c; send_byte(8'h65, a); chk(!a, "R2 wrong type", {15'h0, a}, 16'h0); stop_c;
    start_c; send_byte(8'h5D, a); chk(!a, "R2 bit3 set", {15'h0, a}, 16'h0); stop_c;

    // R3 busy polling
    busy = 1;
    start_c; send_byte(8'h55, a); chk(!a, "R3 busy nack", {15'h0, a}, 16'h0); stop_c;
    busy = 0;
    start_c; send_byte(8'h55, a); chk(a, "R3 ack after busy", {15'h0, a}, 16'h1);
    send_byte(8'hD8, a); exp_q.push_back(item(3'd2, 4'h2, 8'h00)); stop_c;   // R6

    // R6 wiper to register 3
    start_c; send_byte(8'h55, a); send_byte(8'hEC, a);
    chk(a, "R6 xfer ack", {15'h0, a}, 16'h1);
    exp_q.push_back(item(3'd3, 4'h3, 8'h00)); stop_c;

    // R4 illegal opcode and wiper op with nonzero bank
    start_c; send_byte(8'h55, a); send_byte(8'h00, a);
    chk(!a, "R4 bad opcode", {15'h0, a}, 16'h0); stop_c;
    start_c; send_byte(8'h55, a); send_byte(8'hA1, a);
    chk(!a, "R4 wiper op bank1", {15'h0, a}, 16'h0);
    send_byte(8'h77, a); stop_c;

    // R8 step mode: up, up, down; stop adds nothing
    start_c; send_byte(8'h55, a); send_byte(8'h20, a);
    chk(a, "R8 step ack", {15'h0, a}, 16'h1);
    exp_q.push_back(item(3'd4, 4'h0, 8'h00));
    exp_q.push_back(item(3'd4, 4'h0, 8'h00));
    exp_q.push_back(item(3'd5, 4'h0, 8'h00));
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); stop_c;

    // R9 too many bytes and too few bytes
    start_c; send_byte(8'h55, a); send_byte(8'hA0, a); send_byte(8'h12, a);
    send_byte(8'h34, a); chk(!a, "R9 extra byte nack", {15'h0, a}, 16'h0); stop_c;
    start_c; send_byte(8'h55, a); send_byte(8'hC6, a); stop_c;

    // R1 repeated start aborts a partial write
    start_c; send_byte(8'h55, a); send_byte(8'hA0, a);
    start_c; send_byte(8'h55, a); chk(a, "R1 restart ack", {15'h0, a}, 16'h1);
    send_byte(8'hD4, a); exp_q.push_back(item(3'd2, 4'h1, 8'h00)); stop_c;

    #2000;
    chk(exp_q.size() == 0, "R9 all expected strobes seen", 16'(exp_q.size()), 16'h0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule